// File: doc/BRIEF.md
# Backlight Level to PWM Duty Converter

This block turns an 8-bit brightness request into a 16-bit fixed-point active-duty count and runs the backlight PWM generator from it. The level is first stretched to a U1.16 fraction of full scale. That fraction is multiplied by the configured PWM period, which is masked to a programmable number of bits. The product is then rounded to a duty count. In that count the upper bits give whole period ticks and the remaining low bits give a fraction of a tick.

A newly computed duty count is captured into a shadow register on a write strobe. Software locks the group before it writes, so several register updates can be staged without the output glitching. After the group is unlocked, an update-pending flag rises if the staged value differs from the live one. The staged value is promoted at the next period rollover, and the flag drops on that same edge. The PWM pin is high for the first whole ticks of every period and is held low whenever the enable input is off.

Top module: `bl_pwm_duty`

## Requirements
- R1: On a write, the level L is stretched to 24 bits by repeating it three times (L*0x10101). The unit value is bits [23:8] of that result plus bit 7 as a rounding bit, so L=0xEF gives 0xEFF0 and L=0xFF gives 0x10000.
- R2: The effective bit count is 16 when the bit-count input is 0 or above 16, and equals the input otherwise. The period is masked to its low bit-count bits before use, so 0x40 with a count of 6 masks to 0.
- R3: The duty count is (unit * masked period) shifted right by the bit count, truncated to 16 bits, plus bit (bit count - 1) of the product. For example, 0xEF with period 0x24 and a count of 6 gives 0x86F7.
- R4: The duty count never exceeds the masked period shifted left by (16 - bit count). L=0xFF gives a full-period high time.
- R5: A period counter runs from 0 to masked period - 1 and then wraps. pwm_o is high for every count below the duty count shifted right by (16 - bit count). A masked period of 0 holds the counter at 0 and keeps pwm_o low.
- R6: pwm_o is low in the cycle after any cycle in which pwm_en_i is 0.
- R7: The group is locked only while lock_i and lock_ign_i are both 1. While it is locked, a write reaches only the shadow register: pending_o does not rise and the PWM high time is unchanged.
- R8: pending_o rises on unlock, and on a write while unlocked, only when the shadow value differs from the active value.
- R9: The shadow value becomes active only on a period rollover while the group is unlocked and pending_o is 1. pending_o falls on that same edge, which is within one period of the unlock.
- R10: After reset, the active and shadow counts are 0, pending_o is 0 and pwm_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| level_i | input | LVL_W | Brightness request |
| level_wr_i | input | 1 | Strobe: capture the computed duty count into the shadow register |
| period_i | input | DUTY_W | PWM period value before masking |
| bitcnt_i | input | BC_W | Period bit count; 0 means 16 |
| pwm_en_i | input | 1 | PWM output enable |
| lock_ign_i | input | 1 | Group-lock qualifier; a lock takes effect only when this bit is 1 |
| lock_i | input | 1 | Group lock request |
| pwm_o | output | 1 | Backlight PWM output |
| pending_o | output | 1 | A staged duty count is waiting for a period rollover |

## Verification
The bench targets the arithmetic corners, each of which changes the measured high time per period:
- rounding at bits 7 and (bit count - 1), which changes high times by one tick when it is dropped;
- a bit count of 0 or above 16;
- a period whose set bits all lie above the mask, which must give a silent output rather than a counter that runs to 65535;
- full scale, which must fill the whole period and not wrap to zero.

The lock sequence is also covered:
- a lock request without the qualifier bit;
- a write under lock, where a broken buffer would change the output early or raise the pending flag too soon;
- an unlock with an unchanged value, where a flag that ignores the comparison would go high;
- the promotion time, where a buffer that promotes on the unlock edge instead of the rollover clears the flag too early or never.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
    localparam int BL_LVL_W  = 8;
    localparam int BL_DUTY_W = 16;
    localparam int BL_BC_W   = 5;
endpackage

// File: rtl/bl_level_scaler.sv
module bl_level_scaler #(
    parameter int LVL_W  = bl_pwm_pkg::BL_LVL_W,
    parameter int DUTY_W = bl_pwm_pkg::BL_DUTY_W,
    parameter int BC_W   = bl_pwm_pkg::BL_BC_W
) (
    input  logic [LVL_W-1:0]  level_i,
    input  logic [DUTY_W-1:0] period_i,
    input  logic [BC_W-1:0]   bitcnt_i,
    output logic [DUTY_W-1:0] period_m_o,
    output logic [DUTY_W-1:0] duty_o,
    output logic [BC_W-1:0]   frac_o
);
    localparam int EXP_W  = 3 * LVL_W;
    localparam int U_W    = 2 * LVL_W + 1;
    localparam int PROD_W = U_W + DUTY_W;
    localparam logic [BC_W-1:0] FULL = BC_W'(DUTY_W);

    logic [BC_W-1:0]   bits;
    logic [EXP_W-1:0]  expanded;
    logic [U_W-1:0]    unit;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] pre_round;
    logic [PROD_W-1:0] shifted;

    always_comb begin
        bits       = (bitcnt_i == '0 || bitcnt_i > FULL) ? FULL : bitcnt_i;
        period_m_o = period_i & ~({DUTY_W{1'b1}} << bits);
        expanded   = {3{level_i}};
        unit       = {1'b0, expanded[EXP_W-1 -: 2*LVL_W]}
                   + {{(U_W-1){1'b0}}, expanded[LVL_W-1]};
        prod       = PROD_W'(unit) * PROD_W'(period_m_o);
        pre_round  = prod >> (bits - 1'b1);
        shifted    = pre_round >> 1;
        duty_o     = shifted[DUTY_W-1:0] + {{(DUTY_W-1){1'b0}}, pre_round[0]};
        frac_o     = FULL - bits;
    end
endmodule

// File: rtl/bl_duty_buffer.sv
module bl_duty_buffer #(
    parameter int DUTY_W = bl_pwm_pkg::BL_DUTY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic              lock_i,
    input  logic              lock_ign_i,
    input  logic              roll_i,
    output logic [DUTY_W-1:0] active_o,
    output logic              pending_o,
    output logic              locked_o
);
    typedef struct packed {
        logic [DUTY_W-1:0] shadow;
        logic [DUTY_W-1:0] active;
        logic              pending;
        logic              locked;
    } buf_state_t;

    buf_state_t state_d, state_q;
    logic       lock_now;
    logic       unlock_ev;

    always_comb begin
        state_d   = state_q;
        lock_now  = lock_i & lock_ign_i;
        unlock_ev = state_q.locked & ~lock_now;
        state_d.locked = lock_now;
        if (wr_i) begin
            state_d.shadow = duty_i;
        end
        if (state_q.pending && !lock_now && roll_i) begin
            state_d.active  = state_q.shadow;
            state_d.pending = 1'b0;
        end
        if (!lock_now && (wr_i || unlock_ev)) begin
            state_d.pending = (state_d.shadow != state_d.active);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign active_o  = state_q.active;
    assign pending_o = state_q.pending;
    assign locked_o  = state_q.locked;
endmodule

// File: rtl/bl_pwm_gen.sv
module bl_pwm_gen #(
    parameter int DUTY_W = bl_pwm_pkg::BL_DUTY_W,
    parameter int BC_W   = bl_pwm_pkg::BL_BC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [DUTY_W-1:0] period_m_i,
    input  logic [BC_W-1:0]   frac_i,
    input  logic [DUTY_W-1:0] active_i,
    output logic              roll_o,
    output logic              pwm_o
);
    typedef struct packed {
        logic [DUTY_W-1:0] cnt;
        logic              pwm;
    } gen_state_t;

    gen_state_t        state_d, state_q;
    logic [DUTY_W-1:0] thresh;
    logic              zero_period;

    always_comb begin
        state_d     = state_q;
        zero_period = (period_m_i == '0);
        thresh      = active_i >> frac_i;
        roll_o      = zero_period || (state_q.cnt >= period_m_i - 1'b1);
        state_d.cnt = roll_o ? '0 : state_q.cnt + 1'b1;
        state_d.pwm = en_i && !zero_period && (state_q.cnt < thresh);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pwm_o = state_q.pwm;
endmodule

// File: rtl/bl_pwm_duty.sv
module bl_pwm_duty #(
    parameter int LVL_W  = bl_pwm_pkg::BL_LVL_W,
    parameter int DUTY_W = bl_pwm_pkg::BL_DUTY_W,
    parameter int BC_W   = bl_pwm_pkg::BL_BC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  level_i,
    input  logic              level_wr_i,
    input  logic [DUTY_W-1:0] period_i,
    input  logic [BC_W-1:0]   bitcnt_i,
    input  logic              pwm_en_i,
    input  logic              lock_ign_i,
    input  logic              lock_i,
    output logic              pwm_o,
    output logic              pending_o
);
    logic [DUTY_W-1:0] period_m;
    logic [DUTY_W-1:0] duty_calc;
    logic [BC_W-1:0]   frac;
    logic [DUTY_W-1:0] active;
    logic              roll;
    logic              locked;

    bl_level_scaler #(.LVL_W(LVL_W), .DUTY_W(DUTY_W), .BC_W(BC_W)) u_scaler (
        .level_i    (level_i),
        .period_i   (period_i),
        .bitcnt_i   (bitcnt_i),
        .period_m_o (period_m),
        .duty_o     (duty_calc),
        .frac_o     (frac)
    );

    bl_duty_buffer #(.DUTY_W(DUTY_W)) u_buffer (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (level_wr_i),
        .duty_i     (duty_calc),
        .lock_i     (lock_i),
        .lock_ign_i (lock_ign_i),
        .roll_i     (roll),
        .active_o   (active),
        .pending_o  (pending_o),
        .locked_o   (locked)
    );

    bl_pwm_gen #(.DUTY_W(DUTY_W), .BC_W(BC_W)) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (pwm_en_i),
        .period_m_i (period_m),
        .frac_i     (frac),
        .active_i   (active),
        .roll_o     (roll),
        .pwm_o      (pwm_o)
    );
endmodule

// File: rtl/bl_pwm_duty_chk.sv
module bl_pwm_duty_chk #(
    parameter int DUTY_W = bl_pwm_pkg::BL_DUTY_W,
    parameter int BC_W   = bl_pwm_pkg::BL_BC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwm_en_i,
    input logic              pwm_o,
    input logic              pending_o,
    input logic              locked,
    input logic              roll,
    input logic [DUTY_W-1:0] active,
    input logic [DUTY_W-1:0] duty_calc,
    input logic [DUTY_W-1:0] period_m,
    input logic [BC_W-1:0]   frac
);
    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_en_i |=> !pwm_o); // R6

    AST_ACTIVE_ONLY_AT_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active) |-> $past(roll && pending_o && !locked)); // R9

    AST_PEND_FALLS_AT_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending_o) |-> $past(roll)); // R9

    AST_NO_PEND_RISE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending_o) |-> !locked); // R7

    AST_DUTY_WITHIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(duty_calc) <= (32'(period_m) << frac))); // R4

    AST_SILENT_ZERO_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (period_m == '0) |=> (!pwm_o || $past(period_m) != '0)); // R5
endmodule

bind bl_pwm_duty bl_pwm_duty_chk #(.DUTY_W(DUTY_W), .BC_W(BC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwm_en_i  (pwm_en_i),
    .pwm_o     (pwm_o),
    .pending_o (pending_o),
    .locked    (locked),
    .roll      (roll),
    .active    (active),
    .duty_calc (duty_calc),
    .period_m  (period_m),
    .frac      (frac)
);

// File: tb/tb_bl_pwm_duty.sv
module tb_bl_pwm_duty;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  level_i = '0;
    logic        level_wr_i = 1'b0;
    logic [15:0] period_i = '0;
    logic [4:0]  bitcnt_i = '0;
    logic        pwm_en_i = 1'b0;
    logic        lock_ign_i = 1'b0;
    logic        lock_i = 1'b0;
    logic        pwm_o;
    logic        pending_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bl_pwm_duty dut (
        .clk(clk), .rst_n(rst_n), .level_i(level_i), .level_wr_i(level_wr_i),
        .period_i(period_i), .bitcnt_i(bitcnt_i), .pwm_en_i(pwm_en_i),
        .lock_ign_i(lock_ign_i), .lock_i(lock_i), .pwm_o(pwm_o), .pending_o(pending_o)
    );

    typedef struct packed {
        logic [7:0]  lvl;
        logic [15:0] per;
        logic [4:0]  bc;
        logic [15:0] win;
        logic [15:0] high;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{8'hEF, 16'h0024, 5'd6,  16'd36,  16'd33},  // R3 worked example
        '{8'hFF, 16'h0024, 5'd6,  16'd36,  16'd36},  // R4 full scale
        '{8'h00, 16'h0024, 5'd6,  16'd36,  16'd0},   // R1 zero level
        '{8'h80, 16'h0064, 5'd7,  16'd100, 16'd50},  // R1 rounding bit set
        '{8'h80, 16'h01F3, 5'd8,  16'd243, 16'd121}, // R2 period masking
        '{8'h40, 16'h012C, 5'd0,  16'd300, 16'd75},  // R2 count 0 means 16
        '{8'h01, 16'h0024, 5'd6,  16'd36,  16'd0},   // R3 product rounding
        '{8'h7F, 16'h000A, 5'd4,  16'd10,  16'd4},   // R3 small period
        '{8'hFF, 16'h0040, 5'd6,  16'd16,  16'd0},   // R5 masked period 0
        '{8'h40, 16'h012C, 5'd20, 16'd300, 16'd75}   // R2 count above 16
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_level(input logic [7:0] l);
        @(negedge clk);
        level_i    = l;
        level_wr_i = 1'b1;
        @(negedge clk);
        level_wr_i = 1'b0;
    endtask

    task automatic settle();
        int n = 0;
        while (pending_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic measure(input int win, output int high);
        high = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (pwm_o) high++;
        end
    endtask

    initial begin
        int h;
        int n;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(pending_o == 1'b0, "R10 pending after reset", pending_o, 0);
        check(pwm_o == 1'b0, "R10 pwm after reset", pwm_o, 0);
        rst_n = 1'b1;
        period_i = 16'h0024; bitcnt_i = 5'd6; pwm_en_i = 1'b1;
        repeat (2) @(negedge clk);
        measure(36, h);
        check(h == 0, "R10 active count zero after reset", h, 0);

        // Vector table: R1 R2 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            period_i = VECS[v].per;
            bitcnt_i = VECS[v].bc;
            write_level(VECS[v].lvl);
            settle();
            measure(int'(VECS[v].win), h);
            check(h == int'(VECS[v].high), $sformatf("R1 R2 R3 R4 R5 vector %0d high ticks", v),
                  h, int'(VECS[v].high));
        end

        // R6 enable gating
        @(negedge clk);
        period_i = 16'h0024; bitcnt_i = 5'd6;
        write_level(8'hEF);
        settle();
        pwm_en_i = 1'b0;
        repeat (2) @(negedge clk);
        measure(36, h);
        check(h == 0, "R6 output off while disabled", h, 0);
        pwm_en_i = 1'b1;
        repeat (2) @(negedge clk);
        measure(36, h);
        check(h == 33, "R6 output back when enabled", h, 33);

        // R7 write under lock stays staged
        lock_ign_i = 1'b1; lock_i = 1'b1;
        write_level(8'h00);
        repeat (100) @(negedge clk);
        check(pending_o == 1'b0, "R7 pending stays low while locked", pending_o, 0);
        measure(36, h);
        check(h == 33, "R7 high time unchanged while locked", h, 33);

        // R8 unlock raises pending, R9 promotion within a period
        lock_i = 1'b0;
        @(negedge clk);
        check(pending_o == 1'b1, "R8 pending after unlock with new value", pending_o, 1);
        n = 0;
        while (pending_o && n < 1000) begin
            @(negedge clk);
            n++;
        end
        check(n <= 36, "R9 pending clears within one period", n, 36);
        repeat (2) @(negedge clk);
        measure(36, h);
        check(h == 0, "R9 new value active after rollover", h, 0);

        // R7 lock without qualifier bit is ignored
        lock_ign_i = 1'b0; lock_i = 1'b1;
        write_level(8'hEF);
        check(pending_o == 1'b1, "R7 lock without qualifier ignored", pending_o, 1);
        settle();
        measure(36, h);
        check(h == 33, "R7 value applied without qualifier", h, 33);

        // R8 unlock with unchanged value leaves pending low
        lock_ign_i = 1'b1; lock_i = 1'b1;
        write_level(8'hEF);
        repeat (5) @(negedge clk);
        lock_i = 1'b0;
        @(negedge clk);
        check(pending_o == 1'b0, "R8 no pending when value unchanged", pending_o, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule